// File: doc/BRIEF.md
# Packed Day-Hour-Minute-Second Counter with Alarm

This block keeps elapsed time in a single 32-bit word built from four mixed-radix fields: a 15-bit day count, an hour count, a minute count and a second count. Each pulse on the tick input advances the seconds field. A full field wraps to zero and carries into the next field. Software loads arrive as one-cycle strobes from a write controller, and a time load replaces the whole word in the cycle it is applied.

The running time is compared against an alarm word that uses the same packed layout. Two alarm pulses come from that compare. The time-of-day pulse ignores the day field. The day-qualified pulse needs the whole word to match. Each advance also produces one-cycle pulses for the second, for the minute rollover, for the hour rollover and for the 24-hour rollover.

A separate stopwatch down-counter counts ticks toward zero and raises its own pulse when it gets there. All event outputs are registered. Each one is high for exactly the one cycle that follows the clock edge where the tick was taken.

Top module: `packed_time_counter`

## Requirements
- R1: After reset the time word, the alarm word and the stopwatch count are all zero, and every event output is low.
- R2: The time word packs seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and days in bits 31:17. A tick taken without a time load adds one second and pulses the second event for one cycle.
- R3: Seconds count 0 to 59. A tick at 59 sets seconds to 0, adds one minute and pulses the minute event.
- R4: Minutes count 0 to 59. A carry into minutes at 59 sets minutes to 0, adds one hour and pulses the hour event.
- R5: Hours count 0 to 23. A carry into hours at 23 sets hours to 0, adds one day and pulses the 24-hour event.
- R6: The day field wraps from 32767 to 0.
- R7: A time load replaces all four fields at the next clock edge. A tick in the same cycle is ignored, and no time event pulses in that cycle.
- R8: With no tick and no time load, the time word holds its value and the time events stay low.
- R9: The time-of-day alarm pulses when a tick moves the time to a value whose bits 16:0 equal the alarm word's bits 16:0, whatever the day field holds.
- R10: The day-qualified alarm pulses only when a tick moves the time to a value equal to the whole alarm word. An alarm load updates the alarm word at the next clock edge.
- R11: A loaded nonzero stopwatch count decrements once per tick. The stopwatch event pulses on the tick that takes the count from 1 to 0, and the count then stays at 0.
- R12: A stopwatch load of zero leaves the stopwatch idle. Later ticks neither change the count nor pulse the stopwatch event.
- R13: A stopwatch load in the same cycle as a tick takes the loaded value, and that tick does not decrement it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second advance strobe |
| time_ld_i | input | 1 | Committed time load strobe |
| time_ld_val_i | input | 32 | Packed time value to load |
| alarm_ld_i | input | 1 | Committed alarm load strobe |
| alarm_ld_val_i | input | 32 | Packed alarm value to load |
| sw_ld_i | input | 1 | Stopwatch load strobe |
| sw_ld_val_i | input | SW_W | Stopwatch start count |
| time_o | output | 32 | Current packed time |
| alarm_o | output | 32 | Current packed alarm |
| sw_count_o | output | SW_W | Current stopwatch count |
| evt_sec_o | output | 1 | Second event pulse |
| evt_min_o | output | 1 | Minute rollover pulse |
| evt_hour_o | output | 1 | Hour rollover pulse |
| evt_day_o | output | 1 | 24-hour rollover pulse |
| evt_alarm_tod_o | output | 1 | Time-of-day alarm pulse |
| evt_alarm_day_o | output | 1 | Day-qualified alarm pulse |
| evt_sw_o | output | 1 | Stopwatch expiry pulse |

## Verification
The checker tests rules that hold on every cycle:
- a second pulse follows each accepted tick;
- a load always wins over a tick in the same cycle;
- the time holds while nothing happens;
- a minute or 24-hour pulse appears only with zeroed lower fields;
- the day-qualified alarm implies the time-of-day alarm;
- the time-of-day alarm agrees with the compare;
- an idle stopwatch stays idle.

Some behaviour only the bench scenarios can show. These are the exact carry chains at 59, 59 and 23, the wrap of the day field at 32767, an alarm that matches the time of day but not the day, and the tick on which the stopwatch reaches zero. The bench checks each of these against a model that counts plain seconds.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 15;
  localparam int TIME_W = SEC_W + MIN_W + HOUR_W + DAY_W;
  localparam int TOD_W  = SEC_W + MIN_W + HOUR_W;

  localparam int SEC_LIMIT  = 60;
  localparam int MIN_LIMIT  = 60;
  localparam int HOUR_LIMIT = 24;

  // Packed layout, most significant field first: day | hour | min | sec
  typedef struct packed {
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } ptc_time_t;

  function automatic logic tod_equal(input ptc_time_t a, input ptc_time_t b);
    return (a.hour == b.hour) && (a.min == b.min) && (a.sec == b.sec);
  endfunction

  function automatic logic full_equal(input ptc_time_t a, input ptc_time_t b);
    return tod_equal(a, b) && (a.day == b.day);
  endfunction
endpackage

// File: rtl/ptc_wrap_field.sv
module ptc_wrap_field #(
  parameter int W     = 6,
  parameter int LIMIT = 60
) (
  input  logic [W-1:0] val_i,
  input  logic         carry_i,
  output logic [W-1:0] nxt_o,
  output logic         carry_o
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  always_comb begin
    nxt_o   = val_i;
    carry_o = 1'b0;
    if (carry_i) begin
      if (val_i >= LAST) begin
        nxt_o   = '0;
        carry_o = 1'b1;
      end else begin
        nxt_o = val_i + W'(1);
      end
    end
  end
endmodule

// File: rtl/ptc_time_adv.sv
module ptc_time_adv
  import ptc_pkg::*;
(
  input  ptc_time_t cur_i,
  input  logic      adv_i,
  output ptc_time_t nxt_o,
  output logic      roll_sec_o,
  output logic      roll_min_o,
  output logic      roll_hour_o
);
  ptc_wrap_field #(.W(SEC_W), .LIMIT(SEC_LIMIT)) u_sec (
    .val_i(cur_i.sec), .carry_i(adv_i), .nxt_o(nxt_o.sec), .carry_o(roll_sec_o)
  );
  ptc_wrap_field #(.W(MIN_W), .LIMIT(MIN_LIMIT)) u_min (
    .val_i(cur_i.min), .carry_i(roll_sec_o), .nxt_o(nxt_o.min), .carry_o(roll_min_o)
  );
  ptc_wrap_field #(.W(HOUR_W), .LIMIT(HOUR_LIMIT)) u_hour (
    .val_i(cur_i.hour), .carry_i(roll_min_o), .nxt_o(nxt_o.hour), .carry_o(roll_hour_o)
  );

  // Day field wraps naturally at its full width.
  assign nxt_o.day = cur_i.day + DAY_W'(roll_hour_o);
endmodule

// File: rtl/ptc_stopwatch.sv
module ptc_stopwatch #(
  parameter int SW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            ld_i,
  input  logic [SW_W-1:0] ld_val_i,
  output logic [SW_W-1:0] count_o,
  output logic            evt_o
);
  localparam logic [SW_W-1:0] ONE = SW_W'(1);

  logic running;
  logic expiring;

  assign running  = (count_o != '0);
  assign expiring = tick_i && !ld_i && (count_o == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= '0;
      evt_o   <= 1'b0;
    end else begin
      evt_o <= expiring;
      if (ld_i)                  count_o <= ld_val_i;
      else if (tick_i && running) count_o <= count_o - ONE;
    end
  end
endmodule

// File: rtl/packed_time_counter.sv
module packed_time_counter
  import ptc_pkg::*;
#(
  parameter int SW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              time_ld_i,
  input  logic [TIME_W-1:0] time_ld_val_i,
  input  logic              alarm_ld_i,
  input  logic [TIME_W-1:0] alarm_ld_val_i,
  input  logic              sw_ld_i,
  input  logic [SW_W-1:0]   sw_ld_val_i,
  output logic [TIME_W-1:0] time_o,
  output logic [TIME_W-1:0] alarm_o,
  output logic [SW_W-1:0]   sw_count_o,
  output logic              evt_sec_o,
  output logic              evt_min_o,
  output logic              evt_hour_o,
  output logic              evt_day_o,
  output logic              evt_alarm_tod_o,
  output logic              evt_alarm_day_o,
  output logic              evt_sw_o
);
  ptc_time_t time_q, alarm_q, nxt_time;
  logic      adv;
  logic      roll_sec, roll_min, roll_hour;
  logic      tod_hit, full_hit;

  // A load wins over a tick in the same cycle.
  assign adv = tick_i && !time_ld_i;

  ptc_time_adv u_adv (
    .cur_i      (time_q),
    .adv_i      (adv),
    .nxt_o      (nxt_time),
    .roll_sec_o (roll_sec),
    .roll_min_o (roll_min),
    .roll_hour_o(roll_hour)
  );

  assign tod_hit  = adv && tod_equal(nxt_time, alarm_q);
  assign full_hit = adv && full_equal(nxt_time, alarm_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q          <= '0;
      alarm_q         <= '0;
      evt_sec_o       <= 1'b0;
      evt_min_o       <= 1'b0;
      evt_hour_o      <= 1'b0;
      evt_day_o       <= 1'b0;
      evt_alarm_tod_o <= 1'b0;
      evt_alarm_day_o <= 1'b0;
    end else begin
      if (time_ld_i) time_q <= ptc_time_t'(time_ld_val_i);
      else           time_q <= nxt_time;
      if (alarm_ld_i) alarm_q <= ptc_time_t'(alarm_ld_val_i);
      evt_sec_o       <= adv;
      evt_min_o       <= roll_sec;
      evt_hour_o      <= roll_min;
      evt_day_o       <= roll_hour;
      evt_alarm_tod_o <= tod_hit;
      evt_alarm_day_o <= full_hit;
    end
  end

  ptc_stopwatch #(.SW_W(SW_W)) u_sw (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .ld_i    (sw_ld_i),
    .ld_val_i(sw_ld_val_i),
    .count_o (sw_count_o),
    .evt_o   (evt_sw_o)
  );

  assign time_o  = time_q;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int SW_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_i,
  input logic            time_ld_i,
  input logic [31:0]     time_ld_val_i,
  input logic            alarm_ld_i,
  input logic [31:0]     alarm_ld_val_i,
  input logic            sw_ld_i,
  input logic [SW_W-1:0] sw_ld_val_i,
  input logic [31:0]     time_o,
  input logic [31:0]     alarm_o,
  input logic [SW_W-1:0] sw_count_o,
  input logic            evt_sec_o,
  input logic            evt_min_o,
  input logic            evt_hour_o,
  input logic            evt_day_o,
  input logic            evt_alarm_tod_o,
  input logic            evt_alarm_day_o,
  input logic            evt_sw_o
);
  assert_sec_evt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !time_ld_i) |=> evt_sec_o);

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    time_ld_i |=> (time_o == $past(time_ld_val_i)) && !evt_sec_o && !evt_min_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !time_ld_i) |=> $stable(time_o) && !evt_sec_o && !evt_day_o);

  assert_min_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_min_o |-> (time_o[5:0] == 6'd0) && evt_sec_o);

  assert_day_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_day_o |-> (time_o[16:0] == 17'd0) && evt_hour_o);

  assert_tod_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !time_ld_i && !alarm_ld_i) |=>
      (evt_alarm_tod_o == (time_o[16:0] == alarm_o[16:0])));

  assert_day_implies_tod_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_alarm_day_o |-> evt_alarm_tod_o);

  assert_alarm_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_ld_i |=> alarm_o == $past(alarm_ld_val_i));

  assert_sw_evt_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sw_o |-> sw_count_o == '0);

  assert_sw_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_count_o == '0 && !sw_ld_i) |=> (sw_count_o == '0) && !evt_sw_o);

  assert_sw_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ld_i |=> sw_count_o == $past(sw_ld_val_i));
endmodule

bind packed_time_counter ptc_checker #(.SW_W(SW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .time_ld_i(time_ld_i),
  .time_ld_val_i(time_ld_val_i), .alarm_ld_i(alarm_ld_i),
  .alarm_ld_val_i(alarm_ld_val_i), .sw_ld_i(sw_ld_i), .sw_ld_val_i(sw_ld_val_i),
  .time_o(time_o), .alarm_o(alarm_o), .sw_count_o(sw_count_o),
  .evt_sec_o(evt_sec_o), .evt_min_o(evt_min_o), .evt_hour_o(evt_hour_o),
  .evt_day_o(evt_day_o), .evt_alarm_tod_o(evt_alarm_tod_o),
  .evt_alarm_day_o(evt_alarm_day_o), .evt_sw_o(evt_sw_o)
);

// File: tb/packed_time_counter_tb.sv
module packed_time_counter_tb;
  localparam int SW_W = 16;
  localparam longint DAY_S = 86400;
  localparam longint WRAP  = 32768 * 86400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 0, time_ld_i = 0, alarm_ld_i = 0, sw_ld_i = 0;
  logic [31:0] time_ld_val_i = '0, alarm_ld_val_i = '0;
  logic [SW_W-1:0] sw_ld_val_i = '0;
  logic [31:0] time_o, alarm_o;
  logic [SW_W-1:0] sw_count_o;
  logic evt_sec_o, evt_min_o, evt_hour_o, evt_day_o;
  logic evt_alarm_tod_o, evt_alarm_day_o, evt_sw_o;

  always #5 clk = ~clk;

  packed_time_counter #(.SW_W(SW_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .time_ld_i(time_ld_i),
    .time_ld_val_i(time_ld_val_i), .alarm_ld_i(alarm_ld_i),
    .alarm_ld_val_i(alarm_ld_val_i), .sw_ld_i(sw_ld_i), .sw_ld_val_i(sw_ld_val_i),
    .time_o(time_o), .alarm_o(alarm_o), .sw_count_o(sw_count_o),
    .evt_sec_o(evt_sec_o), .evt_min_o(evt_min_o), .evt_hour_o(evt_hour_o),
    .evt_day_o(evt_day_o), .evt_alarm_tod_o(evt_alarm_tod_o),
    .evt_alarm_day_o(evt_alarm_day_o), .evt_sw_o(evt_sw_o)
  );

  typedef struct packed {
    logic [31:0]     t;
    logic [31:0]     a;
    logic [SW_W-1:0] sw;
    logic [6:0]      ev;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  longint          m_tot = 0;
  logic [31:0]     m_alarm = '0;
  logic [SW_W-1:0] m_sw = '0;

  // Field bounds the bench reads and writes:
  // seconds 5:0, minutes 11:6, hours 16:12, days 31:17.
  function automatic logic [31:0] pk(input longint d, h, m, s);
    logic [31:0] r;
    r[5:0]   = 6'(s);
    r[11:6]  = 6'(m);
    r[16:12] = 5'(h);
    r[31:17] = 15'(d);
    return r;
  endfunction

  function automatic logic [31:0] tot2pk(input longint tot);
    return pk((tot / DAY_S) % 32768, (tot % DAY_S) / 3600, (tot % 3600) / 60, tot % 60);
  endfunction

  function automatic longint pk2tot(input logic [31:0] v);
    return longint'(v[31:17]) * DAY_S + longint'(v[16:12]) * 3600 +
           longint'(v[11:6]) * 60 + longint'(v[5:0]);
  endfunction

  task automatic cyc(input bit tk, input bit tl, input logic [31:0] tv,
                     input bit al, input logic [31:0] av,
                     input bit sl, input logic [SW_W-1:0] sv, input string tag);
    exp_t e;
    bit adv;
    logic [31:0] np;
    @(negedge clk);
    tick_i = tk; time_ld_i = tl; time_ld_val_i = tv;
    alarm_ld_i = al; alarm_ld_val_i = av; sw_ld_i = sl; sw_ld_val_i = sv;
    adv = tk && !tl;
    if (tl) m_tot = pk2tot(tv);
    else if (adv) m_tot = (m_tot + 1) % WRAP;
    np = tot2pk(m_tot);
    e.ev[6] = adv;
    e.ev[5] = adv && (np[5:0] == 0);
    e.ev[4] = adv && (np[11:0] == 0);
    e.ev[3] = adv && (np[16:0] == 0);
    e.ev[2] = adv && (np[16:0] == m_alarm[16:0]);
    e.ev[1] = adv && (np == m_alarm);
    e.ev[0] = 1'b0;
    if (al) m_alarm = av;
    if (sl) m_sw = sv;
    else if (tk && m_sw != 0) begin
      e.ev[0] = (m_sw == 1);
      m_sw = m_sw - 1;
    end
    e.t = np; e.a = m_alarm; e.sw = m_sw;
    @(posedge clk);
    #1;
    tick_i = 0; time_ld_i = 0; alarm_ld_i = 0; sw_ld_i = 0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic tk1(input string tag);
    cyc(1, 0, '0, 0, '0, 0, '0, tag);
  endtask

  task automatic ldt(input logic [31:0] v, input string tag);
    cyc(0, 1, v, 0, '0, 0, '0, tag);
  endtask

  // Monitor: compare the outputs with the oldest expected item.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      string tg;
      logic [6:0] got;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      got = {evt_sec_o, evt_min_o, evt_hour_o, evt_day_o,
             evt_alarm_tod_o, evt_alarm_day_o, evt_sw_o};
      n_checks++;
      if (time_o !== e.t || alarm_o !== e.a || sw_count_o !== e.sw || got !== e.ev) begin
        n_fail++;
        $display("FAIL %s: time=%h alarm=%h sw=%0d ev=%b expected time=%h alarm=%h sw=%0d ev=%b",
                 tg, time_o, alarm_o, sw_count_o, got, e.t, e.a, e.sw, e.ev);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (time_o !== 0 || alarm_o !== 0 || sw_count_o !== 0 ||
        {evt_sec_o, evt_min_o, evt_hour_o, evt_day_o, evt_alarm_tod_o,
         evt_alarm_day_o, evt_sw_o} !== 0) begin
      n_fail++;
      $display("FAIL R1: time=%h alarm=%h sw=%0d expected all zero", time_o, alarm_o, sw_count_o);
    end

    // R2: plain seconds counting
    for (int i = 0; i < 3; i++) tk1("R2");
    // R8: idle cycles hold
    for (int i = 0; i < 3; i++) cyc(0, 0, '0, 0, '0, 0, '0, "R8");
    // R3: seconds rollover
    ldt(pk(0, 0, 7, 59), "R7");
    tk1("R3");
    tk1("R3");
    // R4: minute rollover into hour
    ldt(pk(3, 4, 59, 59), "R7");
    tk1("R4");
    // R5: hour rollover into day
    ldt(pk(5, 23, 59, 59), "R7");
    tk1("R5");
    // R6: day field wraps
    ldt(pk(32767, 23, 59, 58), "R7");
    tk1("R6");
    tk1("R6");
    tk1("R6");
    // R7: load with a simultaneous tick
    cyc(1, 1, pk(12, 10, 20, 30), 0, '0, 0, '0, "R7");
    tk1("R7");
    // R9 / R10: alarm compare
    cyc(0, 0, '0, 1, pk(9, 1, 2, 3), 0, '0, "R10");
    ldt(pk(2, 1, 2, 2), "R9");
    tk1("R9");
    tk1("R9");
    ldt(pk(9, 1, 2, 2), "R10");
    tk1("R10");
    tk1("R10");
    // R11: stopwatch countdown
    cyc(0, 0, '0, 0, '0, 1, 16'd3, "R11");
    for (int i = 0; i < 5; i++) tk1("R11");
    // R12: zero load stays idle
    cyc(0, 0, '0, 0, '0, 1, 16'd0, "R12");
    for (int i = 0; i < 3; i++) tk1("R12");
    // R13: load wins over a same-cycle tick
    cyc(1, 0, '0, 0, '0, 1, 16'd5, "R13");
    tk1("R13");
    cyc(1, 0, '0, 0, '0, 1, 16'd1, "R13");
    tk1("R13");
    tk1("R13");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule